// File: doc/BRIEF.md
# Full-Raster Video CDC Elastic FIFO

This block is a dual-clock elastic buffer that sits between a full-raster video source and a video sink. The two sides run on pixel clocks that have no fixed relationship. Both sides use AXI4-Stream valid/ready handshakes. A full-raster source has a fixed pixel rate and cannot wait, so the input side is never stalled. The buffer soaks up short downstream stalls and clock skew. This only works while the source's average rate does not exceed the sink's, because the storage is sized for bursts, not for a sustained mismatch. One data word carries the pixel payload together with its user and last markers.

Pointers cross between the domains as Gray code through flop synchronizers. Each side computes its own view of the fill level. Each side also reports whether that level lies strictly between a programmable low mark and a programmable high mark, which is the safe operating window. A word that arrives while the buffer is full is discarded and sets a sticky overflow flag in the write domain. A read attempt on an empty buffer, once data has flowed at least once, sets a sticky underflow flag in the read domain. A software-facing register can expose both flags and clear them. Each flag is also presented, synchronized, in the opposite domain.

Top module: `vid_cdc_elastic_fifo`

## Requirements
- R1: After reset, `m_valid` is 0, `wr_level` and `rd_level` are 0, `wr_in_zone` and `rd_in_zone` are 0, and all four error outputs are 0.
- R2: Words leave in the order they were accepted. While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` stays unchanged.
- R3: `s_ready` is 1 whenever the write domain is out of reset, so a source that presents a word every write cycle is never stalled.
- R4: The block can stall the output for a time while the input delivers up to DEPTH (default 64) words back to back. When the output resumes, every one of those words is delivered and no overflow is flagged.
- R5: When `s_valid` is 1 and `wr_level` equals DEPTH, the word is discarded, the write pointer does not move, and `wr_ovf` is 1 from the next write clock edge. `wr_level` never exceeds DEPTH.
- R6: `wr_in_zone` and `rd_in_zone` are registered one cycle after their domain's level. Each is 1 exactly when that level is greater than `lo_thr` and less than `hi_thr`.
- R7: `wr_ovf` stays set until it is cleared, and it appears on `rd_ovf` after the synchronizer delay.
- R8: A one-cycle `err_clr` pulse in the write domain clears `wr_ovf` at once. The same pulse clears `rd_udf` after it has crossed into the read domain. If a set and a clear meet in the same cycle, the set wins.
- R9: `rd_udf` is set and stays set when `m_ready` is 1 while the buffer is empty, provided at least one word has been present since reset. It appears on `wr_udf` after the synchronizer delay.
- R10: Before any word has reached the read side, `m_ready` held high on the empty buffer does not set `rd_udf`.
- R11: Once both sides are idle, `wr_level` and `rd_level` report the same occupancy. Neither exceeds DEPTH. The write-side Gray pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side pixel clock |
| wr_rst_n | input | 1 | Write-side asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input ready, high whenever the write side is out of reset |
| s_data | input | DATA_W | Input word: payload, user and last bits together |
| wr_level | output | ADDR_W+1 | Fill level seen from the write side |
| wr_in_zone | output | 1 | Write-side level lies strictly inside the threshold window |
| wr_ovf | output | 1 | Sticky overflow flag, write domain |
| wr_udf | output | 1 | Underflow flag synchronized into the write domain |
| err_clr | input | 1 | One-cycle clear pulse for both sticky flags, write domain |
| rd_clk | input | 1 | Read-side pixel clock |
| rd_rst_n | input | 1 | Read-side asynchronous active-low reset, released synchronously inside |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output ready from the sink |
| m_data | output | DATA_W | Output word |
| rd_level | output | ADDR_W+1 | Fill level seen from the read side |
| rd_in_zone | output | 1 | Read-side level lies strictly inside the threshold window |
| rd_udf | output | 1 | Sticky underflow flag, read domain |
| rd_ovf | output | 1 | Overflow flag synchronized into the read domain |
| lo_thr | input | ADDR_W+1 | Lower bound of the safe window (quasi-static) |
| hi_thr | input | ADDR_W+1 | Upper bound of the safe window (quasi-static) |

## Verification
The bench drives the buffer with five patterns:
- A continuous input stream read by a sink whose ready follows valid. This checks ordering and the always-ready input without any stall.
- A back-to-back burst while the sink is held off, then released. This separates correct absorption from loss or false overflow.
- A fill past capacity. This shows whether surplus words are dropped rather than overwriting stored ones, and whether the overflow flag is set, held and carried across.
- A partial fill inside the threshold window, which tells the in-zone flags apart from the empty and full cases.
- A ready held high on an empty buffer, once before any data and once after. This distinguishes a genuine underflow from the start-up state, and it also exercises the crossed clear.

// File: rtl/vcf_pkg.sv
`timescale 1ns/1ps
package vcf_pkg;
  localparam int unsigned VCF_SYNC_DEFAULT = 2;

  function automatic logic vcf_in_window(input int unsigned lvl,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (lvl > lo) && (lvl < hi);
  endfunction
endpackage

// File: rtl/vcf_sync.sv
`timescale 1ns/1ps
// Release synchronizer: assert asynchronously, deassert on the local clock.
module vcf_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stg_q <= '0;
    else          stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// Multi-flop level synchronizer (for Gray pointers and flag levels).
module vcf_bit_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = vcf_pkg::VCF_SYNC_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// Single-cycle pulse transfer by toggle crossing.
module vcf_pulse_xfer #(
  parameter int unsigned STAGES = vcf_pkg::VCF_SYNC_DEFAULT
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic tgl_q, tgl_d;
  logic tgl_s, prev_q;

  always_comb tgl_d = tgl_q ^ src_pulse;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  vcf_bit_sync #(.W(1), .STAGES(STAGES)) i_tgl_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(tgl_q), .q(tgl_s)
  );

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) prev_q <= 1'b0;
    else            prev_q <= tgl_s;
  end

  assign dst_pulse = tgl_s ^ prev_q;
endmodule

// File: rtl/vcf_level.sv
`timescale 1ns/1ps
// Gray to binary, one reduction per bit.
module vcf_gray2bin #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// Registered safe-window indicator.
module vcf_zone_mon #(
  parameter int unsigned LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] lo_thr,
  input  logic [LW-1:0] hi_thr,
  output logic          in_zone
);
  logic zone_d;

  always_comb zone_d = vcf_pkg::vcf_in_window(32'(level), 32'(lo_thr), 32'(hi_thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_zone <= 1'b0;
    else        in_zone <= zone_d;
  end
endmodule

// File: rtl/vcf_wr_ctl.sv
`timescale 1ns/1ps
module vcf_wr_ctl #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          err_clr,
  input  logic [AW:0]   rd_gray_s,
  input  logic [AW:0]   lo_thr,
  input  logic [AW:0]   hi_thr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wr_gray,
  output logic [AW:0]   level,
  output logic          ovf,
  output logic          in_zone
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(1 << AW);

  logic [PW-1:0] ptr_q, ptr_d, gray_d, rd_bin;
  logic          full, ovf_d;

  vcf_gray2bin #(.W(PW)) i_rd_g2b (.gray(rd_gray_s), .bin(rd_bin));

  always_comb begin
    level  = ptr_q - rd_bin;
    full   = (level == FULL_LVL);
    wr_en  = push & ~full;
    ptr_d  = ptr_q + PW'(1);
    gray_d = ptr_d ^ (ptr_d >> 1);
    ovf_d  = (ovf & ~err_clr) | (push & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      wr_gray <= '0;
    end else if (wr_en) begin
      ptr_q   <= ptr_d;
      wr_gray <= gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= ovf_d;
  end

  assign wr_addr = ptr_q[AW-1:0];

  vcf_zone_mon #(.LW(PW)) i_zone (
    .clk(clk), .rst_n(rst_n), .level(level),
    .lo_thr(lo_thr), .hi_thr(hi_thr), .in_zone(in_zone)
  );
endmodule

// File: rtl/vcf_rd_ctl.sv
`timescale 1ns/1ps
module vcf_rd_ctl #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_ready,
  input  logic          clr,
  input  logic [AW:0]   wr_gray_s,
  input  logic [AW:0]   lo_thr,
  input  logic [AW:0]   hi_thr,
  output logic          m_valid,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0]   rd_gray,
  output logic [AW:0]   level,
  output logic          udf,
  output logic          in_zone
);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] ptr_q, ptr_d, gray_d, wr_bin;
  logic          empty, rd_en, seen_q, seen_d, udf_d;

  vcf_gray2bin #(.W(PW)) i_wr_g2b (.gray(wr_gray_s), .bin(wr_bin));

  always_comb begin
    level   = wr_bin - ptr_q;
    empty   = (level == '0);
    m_valid = ~empty;
    rd_en   = m_ready & ~empty;
    ptr_d   = ptr_q + PW'(1);
    gray_d  = ptr_d ^ (ptr_d >> 1);
    seen_d  = seen_q | ~empty;
    udf_d   = (udf & ~clr) | (m_ready & empty & seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rd_gray <= '0;
    end else if (rd_en) begin
      ptr_q   <= ptr_d;
      rd_gray <= gray_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      udf    <= 1'b0;
    end else begin
      seen_q <= seen_d;
      udf    <= udf_d;
    end
  end

  assign rd_addr = ptr_q[AW-1:0];

  vcf_zone_mon #(.LW(PW)) i_zone (
    .clk(clk), .rst_n(rst_n), .level(level),
    .lo_thr(lo_thr), .hi_thr(hi_thr), .in_zone(in_zone)
  );
endmodule

// File: rtl/vid_cdc_elastic_fifo.sv
`timescale 1ns/1ps
module vid_cdc_elastic_fifo #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = vcf_pkg::VCF_SYNC_DEFAULT
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic [ADDR_W:0]   wr_level,
  output logic              wr_in_zone,
  output logic              wr_ovf,
  output logic              wr_udf,
  input  logic              err_clr,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [ADDR_W:0]   rd_level,
  output logic              rd_in_zone,
  output logic              rd_udf,
  output logic              rd_ovf,
  input  logic [ADDR_W:0]   lo_thr,
  input  logic [ADDR_W:0]   hi_thr
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PW    = ADDR_W + 1;

  logic              wr_rst_q, rd_rst_q;
  logic              wr_en, push, rd_clr_pulse;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [DATA_W-1:0] mem [DEPTH];

  vcf_rst_sync i_wr_rst (.clk(wr_clk), .rst_n_i(wr_rst_n), .rst_n_o(wr_rst_q));
  vcf_rst_sync i_rd_rst (.clk(rd_clk), .rst_n_i(rd_rst_n), .rst_n_o(rd_rst_q));

  assign s_ready = wr_rst_q;
  assign push    = s_valid & s_ready;

  vcf_wr_ctl #(.AW(ADDR_W)) i_wr_ctl (
    .clk(wr_clk), .rst_n(wr_rst_q), .push(push), .err_clr(err_clr),
    .rd_gray_s(rd_gray_s), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray),
    .level(wr_level), .ovf(wr_ovf), .in_zone(wr_in_zone)
  );

  vcf_rd_ctl #(.AW(ADDR_W)) i_rd_ctl (
    .clk(rd_clk), .rst_n(rd_rst_q), .m_ready(m_ready), .clr(rd_clr_pulse),
    .wr_gray_s(wr_gray_s), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .m_valid(m_valid), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .level(rd_level), .udf(rd_udf), .in_zone(rd_in_zone)
  );

  // Pointer crossings
  vcf_bit_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_wptr_sync (
    .clk(rd_clk), .rst_n(rd_rst_q), .d(wr_gray), .q(wr_gray_s)
  );
  vcf_bit_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_rptr_sync (
    .clk(wr_clk), .rst_n(wr_rst_q), .d(rd_gray), .q(rd_gray_s)
  );

  // Flag crossings for status reading in the opposite domain
  vcf_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ovf_sync (
    .clk(rd_clk), .rst_n(rd_rst_q), .d(wr_ovf), .q(rd_ovf)
  );
  vcf_bit_sync #(.W(1), .STAGES(SYNC_STAGES)) i_udf_sync (
    .clk(wr_clk), .rst_n(wr_rst_q), .d(rd_udf), .q(wr_udf)
  );

  vcf_pulse_xfer #(.STAGES(SYNC_STAGES)) i_clr_xfer (
    .src_clk(wr_clk), .src_rst_n(wr_rst_q), .src_pulse(err_clr),
    .dst_clk(rd_clk), .dst_rst_n(rd_rst_q), .dst_pulse(rd_clr_pulse)
  );

  // Storage: written in the write domain, read combinationally at the head.
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= s_data;
  end

  assign m_data = mem[rd_addr];
endmodule

// File: rtl/vcf_checker.sv
`timescale 1ns/1ps
module vcf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [ADDR_W:0]   wr_level,
  input logic [ADDR_W:0]   wr_gray,
  input logic              wr_ovf,
  input logic              err_clr,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [ADDR_W:0]   rd_level,
  input logic              rd_udf,
  input logic              rd_clr_pulse
);
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(1 << ADDR_W);

  p_wr_level_max_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_level <= FULL_LVL);

  p_ovf_on_full_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (s_valid && s_ready && wr_level == FULL_LVL) |=> wr_ovf);

  p_full_drop_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (s_valid && s_ready && wr_level == FULL_LVL) |=> (wr_gray == $past(wr_gray)));

  p_ovf_sticky_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ovf && !err_clr) |=> wr_ovf);

  p_gray_step_r11: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_hold_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_udf_sticky_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_udf && !rd_clr_pulse) |=> rd_udf);

  p_rd_level_max_r11: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_level <= FULL_LVL);
endmodule

bind vid_cdc_elastic_fifo vcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_vcf_checker (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .wr_level(wr_level), .wr_gray(wr_gray), .wr_ovf(wr_ovf), .err_clr(err_clr),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .rd_level(rd_level), .rd_udf(rd_udf), .rd_clr_pulse(rd_clr_pulse)
);

// File: tb/test_vid_cdc_elastic_fifo.sv
`timescale 1ns/1ps
module test_vid_cdc_elastic_fifo;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned DEPTH = 1 << AW;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n, rd_rst_n;
  logic          s_valid, s_ready, m_valid, m_ready, err_clr;
  logic [DW-1:0] s_data, m_data;
  logic [AW:0]   wr_level, rd_level, lo_thr, hi_thr;
  logic          wr_in_zone, rd_in_zone, wr_ovf, wr_udf, rd_udf, rd_ovf;

  int            errors = 0;
  int            checks = 0;
  int            rd_mode = 0;   // 0: ready low, 1: ready follows valid, 2: ready high
  int            cyc = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5  wr_clk = ~wr_clk;   // 200 MHz write pixel clock
  always #2.15 rd_clk = ~rd_clk;   // faster, unrelated read pixel clock

  vid_cdc_elastic_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_vid_cdc_elastic_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .wr_level(wr_level), .wr_in_zone(wr_in_zone),
    .wr_ovf(wr_ovf), .wr_udf(wr_udf), .err_clr(err_clr),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .rd_level(rd_level), .rd_in_zone(rd_in_zone),
    .rd_udf(rd_udf), .rd_ovf(rd_ovf), .lo_thr(lo_thr), .hi_thr(hi_thr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Sink model: decide ready at the falling edge, score the transfer at the next rising edge.
  always @(negedge rd_clk) begin
    logic rdy;
    logic [DW-1:0] exp;
    rdy = (rd_mode == 2) ? 1'b1 : (rd_mode == 1) ? (m_valid === 1'b1) : 1'b0;
    m_ready = rdy;
    if (m_valid === 1'b1 && rdy) begin
      if (exp_q.size() == 0) check(1'b0, "R2", "unexpected word", longint'(m_data), 0);
      else begin
        exp = exp_q.pop_front();
        check(m_data == exp, "R2", "output order", longint'(m_data), longint'(exp));
      end
    end
  end

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic push_words(input int n, input int keep, input logic [DW-1:0] base);
    int rdy_low = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      s_valid = 1'b1;
      s_data  = base + DW'(i);
      if (s_ready !== 1'b1) rdy_low++;
      if (i < keep) exp_q.push_back(base + DW'(i));
    end
    @(negedge wr_clk);
    s_valid = 1'b0;
    check(rdy_low == 0, "R3", "s_ready low during input", rdy_low, 0);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(posedge rd_clk);
    repeat (12) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic t_reset();
    rd_mode = 2;                       // ready high on empty before any data
    repeat (20) @(negedge rd_clk);
    check(m_valid == 1'b0, "R1", "m_valid", m_valid, 0);
    check(wr_level == 0 && rd_level == 0, "R1", "levels", {wr_level, rd_level}, 0);
    check(!wr_in_zone && !rd_in_zone, "R1", "zone flags", {wr_in_zone, rd_in_zone}, 0);
    check(!wr_ovf && !rd_ovf && !wr_udf, "R1", "error flags", {wr_ovf, rd_ovf, wr_udf}, 0);
    check(rd_udf == 1'b0, "R10", "underflow before first word", rd_udf, 0);
    rd_mode = 0;
  endtask

  task automatic t_stream();
    rd_mode = 1;
    push_words(40, 40, 32'hA000_0000);
    wait_drain();
    check(exp_q.size() == 0, "R2", "stream words left", exp_q.size(), 0);
    check(wr_ovf == 1'b0, "R3", "overflow on steady stream", wr_ovf, 0);
  endtask

  task automatic t_stall();
    rd_mode = 0;
    push_words(DEPTH, DEPTH, 32'hB000_0000);
    repeat (8) @(negedge rd_clk);
    check(m_valid == 1'b1, "R4", "m_valid while stalled", m_valid, 1);
    rd_mode = 1;
    wait_drain();
    check(exp_q.size() == 0, "R4", "burst words left", exp_q.size(), 0);
    check(wr_ovf == 1'b0, "R4", "overflow on absorbed burst", wr_ovf, 0);
  endtask

  task automatic t_zone();
    rd_mode = 0;
    push_words(10, 10, 32'hC000_0000);
    repeat (12) @(negedge wr_clk);
    check(wr_level == 10, "R11", "wr_level partial", wr_level, 10);
    check(wr_in_zone == 1'b1, "R6", "wr_in_zone at 10", wr_in_zone, 1);
    @(negedge rd_clk);
    check(rd_level == 10, "R11", "rd_level partial", rd_level, 10);
    check(rd_in_zone == 1'b1, "R6", "rd_in_zone at 10", rd_in_zone, 1);
    rd_mode = 1;
    wait_drain();
    check(rd_in_zone == 1'b0, "R6", "rd_in_zone at 0", rd_in_zone, 0);
  endtask

  task automatic t_fill();
    rd_mode = 0;
    push_words(DEPTH + 3, DEPTH, 32'hD000_0000);
    repeat (8) @(negedge wr_clk);
    check(wr_level == DEPTH, "R5", "wr_level at full", wr_level, DEPTH);
    check(wr_ovf == 1'b1, "R5", "wr_ovf after drop", wr_ovf, 1);
    check(wr_in_zone == 1'b0, "R6", "wr_in_zone at full", wr_in_zone, 0);
    repeat (8) @(negedge rd_clk);
    check(rd_level == DEPTH, "R11", "rd_level at full", rd_level, DEPTH);
    check(rd_ovf == 1'b1, "R7", "rd_ovf crossed", rd_ovf, 1);
    rd_mode = 1;
    wait_drain();
    check(exp_q.size() == 0, "R5", "stored words left", exp_q.size(), 0);
    check(wr_level == 0 && rd_level == 0, "R11", "levels after drain", {wr_level, rd_level}, 0);
    check(wr_ovf == 1'b1, "R7", "wr_ovf sticky", wr_ovf, 1);
    check(rd_udf == 1'b0, "R9", "no underflow with valid-led ready", rd_udf, 0);
  endtask

  task automatic t_underflow();
    rd_mode = 2;
    repeat (6) @(negedge rd_clk);
    check(rd_udf == 1'b1, "R9", "rd_udf on empty read", rd_udf, 1);
    rd_mode = 0;
    repeat (6) @(negedge wr_clk);
    check(wr_udf == 1'b1, "R9", "wr_udf crossed", wr_udf, 1);
    check(rd_udf == 1'b1, "R9", "rd_udf sticky", rd_udf, 1);
  endtask

  task automatic t_clear();
    @(negedge wr_clk); err_clr = 1'b1;
    @(negedge wr_clk); err_clr = 1'b0;
    check(wr_ovf == 1'b0, "R8", "wr_ovf after clear", wr_ovf, 0);
    repeat (10) @(negedge rd_clk);
    check(rd_udf == 1'b0, "R8", "rd_udf after clear", rd_udf, 0);
    repeat (10) @(negedge wr_clk);
    check(wr_udf == 1'b0, "R8", "wr_udf after clear", wr_udf, 0);
    check(rd_ovf == 1'b0, "R8", "rd_ovf after clear", rd_ovf, 0);
  endtask

  initial begin
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    s_valid = 1'b0; s_data = '0; m_ready = 1'b0; err_clr = 1'b0;
    lo_thr = 7'd4; hi_thr = 7'd60;
    repeat (5) @(negedge wr_clk);
    wr_rst_n = 1'b1;
    @(negedge rd_clk);
    rd_rst_n = 1'b1;
    repeat (5) @(negedge wr_clk);
    t_reset();
    t_stream();
    t_stall();
    t_zone();
    t_fill();
    t_underflow();
    t_clear();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule